// File: doc/BRIEF.md
# FIFO Transfer Threshold Controller

This block lets a USB device controller start moving packet data before a whole packet is buffered. A single 32-bit control register holds a transmit threshold and a receive threshold, both counted in 32-bit words. It also holds per-direction enables, a power-of-two ratio that derives a bus-side fetch threshold from the transmit threshold, and an arbiter parking enable.

On the transmit side the block watches the fill level of the active IN endpoint FIFO. It pulses `tx_start` when the USB side may begin sending, and `fetch_req` when the bus side should fetch the next chunk from memory. On the receive side it pulses `rx_wr_start` once enough received words have accumulated. For an IN endpoint that holds a token, it drives a parking hint to the DMA arbiter.

A derived fetch threshold below 8 words is clamped to 8, and a sticky error flag is raised. All threshold comparisons are registered. Each request is a one-cycle pulse and rearms only after its condition has gone false.

Top module: `fifo_thresh_ctl`

## Requirements
- R1: After reset, `reg_rd_data` reads 0x0C100020. That means parking enabled (bit 27), constant one at bit 26, receive threshold 8 in bits 25:17, transmit threshold 8 in bits 10:2, and every enable clear. All pulse outputs, `park_en` and `cfg_err` are 0.
- R2: A write with `reg_wr_en` takes effect at the clock edge on which it is sampled. The following fields can be written and read back: bit 27 parking enable, bits 25:17 receive threshold, bit 16 receive enable, bits 12:11 ratio, bits 10:2 transmit threshold, bit 1 isochronous enable and bit 0 non-isochronous enable. Bits 31:28 and 15:13 always read 0 and bit 26 always reads 1, whatever is written.
- R3: The applicable enable is bit 1 when `tx_iso` is 1 and bit 0 otherwise. With that enable set and `tx_pkt_valid` high, `tx_start` pulses one cycle after `tx_level` first reaches the transmit threshold.
- R4: With the applicable enable clear, `tx_start` waits until `tx_level` reaches `tx_pkt_words`, the whole packet.
- R5: A packet shorter than the transmit threshold starts once `tx_level` reaches `tx_pkt_words`.
- R6: `tx_start`, `fetch_req` and `rx_wr_start` are one-cycle pulses. While their condition stays true they do not repeat, and they rearm only after the condition has been false for at least one cycle.
- R7: The fetch threshold is the transmit threshold shifted right by the ratio field (00 /1, 01 /2, 10 /4, 11 /8). With the applicable enable set and `tx_pkt_valid` high, `fetch_req` pulses one cycle after `tx_level` is below the fetch threshold.
- R8: If the shifted value is below 8, the fetch threshold is 8 instead. One cycle after such a configuration is present, `cfg_err` becomes 1 and stays 1 until reset.
- R9: `rx_wr_start` pulses one cycle after the start of either of two conditions: `rx_level` reaches the receive threshold while bit 16 is set, or `rx_pkt_done` is high.
- R10: One cycle after `tok_valid` is high, `park_en` is 1 when bit 27 is set and at least one transmit enable (bit 1 or bit 0) is set. `park_ep` captures `tok_ep` on every cycle with `tok_valid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Control register write strobe |
| reg_wr_data | input | 32 | Control register write data |
| reg_rd_data | output | 32 | Control register read value |
| tx_pkt_valid | input | 1 | An IN packet is pending on the active endpoint |
| tx_iso | input | 1 | Active endpoint is isochronous |
| tx_pkt_words | input | LVL_W | Size of the pending packet in words |
| tx_level | input | LVL_W | Words held in the active transmit FIFO |
| tx_start | output | 1 | Pulse: USB transmission may begin |
| fetch_req | output | 1 | Pulse: fetch next chunk from memory |
| rx_level | input | LVL_W | Words received in the current packet |
| rx_pkt_done | input | 1 | Whole receive packet is present |
| rx_wr_start | output | 1 | Pulse: begin bus-side write-out |
| tok_valid | input | 1 | Token received for an IN endpoint |
| tok_ep | input | EP_W | Endpoint number of that token |
| park_en | output | 1 | Hold DMA arbiter on `park_ep` |
| park_ep | output | EP_W | Endpoint to park on |
| cfg_err | output | 1 | Sticky: fetch threshold was clamped |

## Verification
The assertions assume the following about the inputs. `tx_level` and `rx_level` are stable between clock edges. A register write lands on a clock edge like any other input. Thresholds are programmed at 8 words or more, except when the clamp is being exercised on purpose.

The stimulus changes inputs only a short time after the rising edge. It programs every threshold at 8 or above until the final clamp case. It then writes a valid configuration back, to show that the error flag stays sticky.

// File: rtl/fifo_thresh_ctl.sv
module fifo_thresh_ctl #(
  parameter int LVL_W = 10,
  parameter int EP_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr_en,
  input  logic [31:0]      reg_wr_data,
  output logic [31:0]      reg_rd_data,
  input  logic             tx_pkt_valid,
  input  logic             tx_iso,
  input  logic [LVL_W-1:0] tx_pkt_words,
  input  logic [LVL_W-1:0] tx_level,
  output logic             tx_start,
  output logic             fetch_req,
  input  logic [LVL_W-1:0] rx_level,
  input  logic             rx_pkt_done,
  output logic             rx_wr_start,
  input  logic             tok_valid,
  input  logic [EP_W-1:0]  tok_ep,
  output logic             park_en,
  output logic [EP_W-1:0]  park_ep,
  output logic             cfg_err
);
  localparam logic [8:0] MIN_THR = 9'd8;

  logic       park_q, rx_en_q, iso_q, niso_q;
  logic [8:0] rx_len_q, tx_len_q;
  logic [1:0] ratio_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      park_q   <= 1'b1;
      rx_len_q <= 9'd8;
      rx_en_q  <= 1'b0;
      ratio_q  <= 2'd0;
      tx_len_q <= 9'd8;
      iso_q    <= 1'b0;
      niso_q   <= 1'b0;
    end else if (reg_wr_en) begin
      park_q   <= reg_wr_data[27];
      rx_len_q <= reg_wr_data[25:17];
      rx_en_q  <= reg_wr_data[16];
      ratio_q  <= reg_wr_data[12:11];
      tx_len_q <= reg_wr_data[10:2];
      iso_q    <= reg_wr_data[1];
      niso_q   <= reg_wr_data[0];
    end

  assign reg_rd_data = {4'b0, park_q, 1'b1, rx_len_q, rx_en_q, 3'b0,
                        ratio_q, tx_len_q, iso_q, niso_q};

  logic [8:0] bus_raw, bus_thr;
  logic       tx_en, start_c, fetch_c, rx_c;
  logic       start_q, fetch_q, rx_q;

  assign bus_raw = tx_len_q >> ratio_q;
  assign bus_thr = (bus_raw < MIN_THR) ? MIN_THR : bus_raw;
  assign tx_en   = tx_iso ? iso_q : niso_q;
  assign start_c = tx_pkt_valid && ((tx_level >= tx_pkt_words) ||
                   (tx_en && tx_level >= LVL_W'(tx_len_q)));
  assign fetch_c = tx_pkt_valid && tx_en && (tx_level < LVL_W'(bus_thr));
  assign rx_c    = rx_pkt_done || (rx_en_q && rx_level >= LVL_W'(rx_len_q));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      start_q     <= 1'b0;
      fetch_q     <= 1'b0;
      rx_q        <= 1'b0;
      tx_start    <= 1'b0;
      fetch_req   <= 1'b0;
      rx_wr_start <= 1'b0;
      cfg_err     <= 1'b0;
      park_en     <= 1'b0;
      park_ep     <= '0;
    end else begin
      start_q     <= start_c;
      fetch_q     <= fetch_c;
      rx_q        <= rx_c;
      tx_start    <= start_c & ~start_q;
      fetch_req   <= fetch_c & ~fetch_q;
      rx_wr_start <= rx_c & ~rx_q;
      cfg_err     <= cfg_err | (bus_raw < MIN_THR);
      park_en     <= tok_valid & park_q & (iso_q | niso_q);
      if (tok_valid) park_ep <= tok_ep;
    end

  assert_start_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> !tx_start);
  assert_fetch_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |=> !fetch_req);
  assert_start_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> $past(tx_pkt_valid));
  assert_bus_floor_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_thr >= MIN_THR);
  assert_bus_le_usb_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_len_q >= MIN_THR) |-> (bus_thr <= tx_len_q));
  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);
  assert_park_token_R10: assert property (@(posedge clk) disable iff (!rst_n)
    park_en |-> ($past(tok_valid) && $past(park_q)));
endmodule

// File: tb/fifo_thresh_ctl_tb.sv
module fifo_thresh_ctl_tb;
  localparam int LVL_W = 10;
  localparam int EP_W  = 4;

  logic clk = 0, rst_n = 0;
  logic reg_wr_en = 0;
  logic [31:0] reg_wr_data = 0, reg_rd_data;
  logic tx_pkt_valid = 0, tx_iso = 0;
  logic [LVL_W-1:0] tx_pkt_words = 0, tx_level = 0, rx_level = 0;
  logic rx_pkt_done = 0, tok_valid = 0;
  logic [EP_W-1:0] tok_ep = 0, park_ep;
  logic tx_start, fetch_req, rx_wr_start, park_en, cfg_err;

  fifo_thresh_ctl #(.LVL_W(LVL_W), .EP_W(EP_W)) u_dut (.*);

  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int c_start = 0, c_fetch = 0, c_rx = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_park = 1, m_rxlen = 8, m_rxen = 0, m_ratio = 0, m_txlen = 8, m_iso = 0, m_niso = 0;
  int m_ps = 0, m_pf = 0, m_pr = 0;
  int e_start = 0, e_fetch = 0, e_rx = 0, e_err = 0, e_park = 0, e_ep = 0;

  function automatic int rd_model();
    return (m_park << 27) | (1 << 26) | (m_rxlen << 17) | (m_rxen << 16) |
           (m_ratio << 11) | (m_txlen << 2) | (m_iso << 1) | m_niso;
  endfunction

  always @(posedge clk) if (rst_n) begin
    int en, s, f, r, raw, bus;
    en  = tx_iso ? m_iso : m_niso;
    raw = m_txlen / (1 << m_ratio);
    bus = (raw < 8) ? 8 : raw;
    s = tx_pkt_valid && (int'(tx_level) >= int'(tx_pkt_words) ||
        (en != 0 && int'(tx_level) >= m_txlen));
    f = tx_pkt_valid && en != 0 && int'(tx_level) < bus;
    r = rx_pkt_done || (m_rxen != 0 && int'(rx_level) >= m_rxlen);
    e_start = s && !m_ps; m_ps = s;
    e_fetch = f && !m_pf; m_pf = f;
    e_rx    = r && !m_pr; m_pr = r;
    if (raw < 8) e_err = 1;
    e_park = tok_valid && m_park != 0 && (m_iso != 0 || m_niso != 0);
    if (tok_valid) e_ep = tok_ep;
    if (reg_wr_en) begin
      m_park = reg_wr_data[27]; m_rxlen = reg_wr_data[25:17]; m_rxen = reg_wr_data[16];
      m_ratio = reg_wr_data[12:11]; m_txlen = reg_wr_data[10:2];
      m_iso = reg_wr_data[1]; m_niso = reg_wr_data[0];
    end
  end

  always @(negedge clk) if (rst_n) begin
    chk("R2 rd_data", reg_rd_data, rd_model());
    chk("R3 tx_start", tx_start, e_start);
    chk("R7 fetch_req", fetch_req, e_fetch);
    chk("R9 rx_wr_start", rx_wr_start, e_rx);
    chk("R8 cfg_err", cfg_err, e_err);
    chk("R10 park_en", park_en, e_park);
    chk("R10 park_ep", park_ep, e_ep);
    c_start += tx_start; c_fetch += fetch_req; c_rx += rx_wr_start;
  end

  task automatic step(input int n = 1);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic wr(input logic [31:0] v);
    reg_wr_en = 1; reg_wr_data = v; step(); reg_wr_en = 0;
  endtask

  task automatic clr();
    c_start = 0; c_fetch = 0; c_rx = 0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    step(3);
    #1;
    chk("R1 reset rd_data", reg_rd_data, 32'h0C10_0020);
    chk("R1 reset outputs", {tx_start, fetch_req, rx_wr_start, park_en, cfg_err}, 0);
    rst_n = 1;
    step(2);

    wr(32'hFFFF_FFFF);
    #1 chk("R2 all ones readback", reg_rd_data, 32'h0FFF_1FFF);
    wr((1<<27) | (12<<17) | (1<<16) | (1<<11) | (16<<2) | 2);
    #1 chk("R2 config readback", reg_rd_data, 32'h0C19_0842);

    // R3 / R6 / R7 iso packet, threshold 16, fetch threshold 8
    clr();
    tx_iso = 1; tx_pkt_words = 64; tx_pkt_valid = 1; tx_level = 0;
    for (int i = 0; i <= 20; i++) begin tx_level = i; step(); end
    step(5);
    chk("R3 one start at threshold", c_start, 1);
    chk("R6 no repeat while held", c_start, 1);
    tx_level = 4; step(2); tx_level = 20; step(3);
    chk("R6 rearm after drop", c_start, 2);
    chk("R7 fetch pulses", c_fetch, 2);
    tx_pkt_valid = 0; tx_level = 0; step(2);

    // R4 non-iso disabled: whole packet needed
    clr();
    tx_iso = 0; tx_pkt_words = 32; tx_pkt_valid = 1; tx_level = 20; step(5);
    chk("R4 no start below packet", c_start, 0);
    tx_level = 32; step(3);
    chk("R4 start at full packet", c_start, 1);
    chk("R7 no fetch when disabled", c_fetch, 0);
    tx_pkt_valid = 0; tx_level = 0; step(2);

    // R5 short iso packet
    clr();
    tx_iso = 1; tx_pkt_words = 5; tx_pkt_valid = 1; tx_level = 5; step(3);
    chk("R5 short packet start", c_start, 1);
    tx_pkt_valid = 0; tx_level = 0; step(2);

    // R9 receive threshold 12
    clr();
    for (int i = 0; i <= 15; i++) begin rx_level = i; step(); end
    chk("R9 rx start at threshold", c_rx, 1);
    rx_level = 0; step(2); rx_pkt_done = 1; step(2); rx_pkt_done = 0; step(2);
    chk("R9 rx start on done", c_rx, 2);

    // R10 parking
    tok_ep = 5; tok_valid = 1; step();
    #1 chk("R10 park asserted", {park_en, park_ep}, {1'b1, 4'd5});
    tok_valid = 0; step();
    wr((12<<17) | (16<<2) | 2);
    tok_ep = 3; tok_valid = 1; step();
    #1 chk("R10 park off when disabled", {park_en, park_ep}, {1'b0, 4'd3});
    tok_valid = 0; step();

    // R8 clamp and sticky error
    chk("R8 no error yet", cfg_err, 0);
    wr((3<<11) | (16<<2) | 2);
    tx_iso = 1; tx_pkt_words = 64; tx_pkt_valid = 1; tx_level = 7; step(2);
    #1 chk("R8 error set", cfg_err, 1);
    wr((16<<2) | 2);
    step(2);
    #1 chk("R8 error sticky", cfg_err, 1);
    tx_pkt_valid = 0; step(2);
    finish_run();
  end
endmodule